// File: doc/BRIEF.md
# Sleep Instruction Power-Down Controller

This block sits beside a processor core that runs every instruction over four phases. It watches the instruction word that the core presents with an execute strobe. When the strobe shows the sleep opcode in the decode phase, the block carries the instruction through the remaining phases. In the last phase it pulses the clear lines of the watchdog counter and of its postscaler. At the edge that closes that phase it sets the time-out status bit, clears the power-down status bit and drops the core clock-enable.

While the core sleeps, the phase counter keeps running. A watchdog time-out or a generic wake event is latched as a wake request. A watchdog wake also clears the time-out bit, so software can later tell which source ended the sleep. The clock-enable comes back at the start of the first decode phase that follows the next last-phase cycle. The oscillator, the watchdog counter, interrupt priority and the full instruction decoder are outside this block and appear only as ports.

Top module: `slp_pwr_ctrl`

## Requirements
- R1: During and after reset, before any sleep, `stat_to` and `stat_pd` read 1, `core_clk_en` reads 1, and `wdt_clr` and `wdt_post_clr` read 0.
- R2: When `exec_stb` is high in a phase-1 cycle (`phase` = 2'b00) with `instr` = 16'h0003, `wdt_clr` and `wdt_post_clr` are both high during the phase-4 cycle (`phase` = 2'b11) of that same instruction cycle, and only in that one cycle.
- R3: From the clock edge that ends that phase-4 cycle, `stat_to` is 1, `stat_pd` is 0 and `core_clk_en` is 0.
- R4: Any other instruction word, or the sleep word strobed in any phase other than phase 1, produces no clear pulse and changes neither status bit nor `core_clk_en`.
- R5: A `wdt_timeout` seen while asleep clears `stat_to` at the next clock edge, and `core_clk_en` returns to 1 in the first phase-1 cycle after the next phase-4 cycle.
- R6: A `wake_evt` seen while asleep leaves `stat_to` at 1, and `core_clk_en` returns to 1 in the first phase-1 cycle after the next phase-4 cycle.
- R7: `wdt_timeout` and `wake_evt` have no effect while awake. They neither change `stat_to` nor shorten a later sleep.
- R8: Instruction strobes while asleep are ignored: no clear pulse is produced.
- R9: `stat_pd` stays 0 after a wake-up, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one phase per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| instr | input | 16 | Instruction word under execution |
| exec_stb | input | 1 | Instruction word is valid for execution |
| phase | input | 2 | Phase of the instruction cycle, 2'b00 = phase 1 to 2'b11 = phase 4 |
| wdt_timeout | input | 1 | Watchdog time-out request |
| wake_evt | input | 1 | Generic wake-up request |
| wdt_clr | output | 1 | Single-cycle clear of the watchdog counter |
| wdt_post_clr | output | 1 | Single-cycle clear of the watchdog postscaler |
| stat_to | output | 1 | Time-out status bit |
| stat_pd | output | 1 | Power-down status bit |
| core_clk_en | output | 1 | Core clock-enable, low while asleep |

## Verification
The bench targets the phase alignment of the clear pulses and of the wake-up. A design off by one register would pulse in phase 3 or phase 1, or would release the clock mid-cycle. It separates the two wake sources: a design that clears the time-out bit on every wake, or never, is caught by the status read right after each kind of wake. It also fires both wake inputs while awake, then sleeps and watches the clock-enable stay low for a full instruction cycle. A design that latched those early requests would wake at once. Strobes of other opcodes, of the sleep word outside phase 1, and of any word while asleep must all leave the clear lines quiet.

// File: rtl/slp_pkg.sv
package slp_pkg;
  localparam int unsigned INSTR_W = 16;
  localparam int unsigned PHASE_W = 2;
  localparam logic [INSTR_W-1:0] OPC_SLEEP = 16'h0003;

  typedef enum logic [PHASE_W-1:0] {
    PH_DECODE  = 2'b00,
    PH_IDLE    = 2'b01,
    PH_PROCESS = 2'b10,
    PH_COMMIT  = 2'b11
  } phase_e;
endpackage

// File: rtl/slp_decode.sv
module slp_decode
  import slp_pkg::*;
#(
  parameter int unsigned IW = INSTR_W,
  parameter logic [IW-1:0] OPCODE = OPC_SLEEP[IW-1:0]
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IW-1:0]      instr,
  input  logic               exec_stb,
  input  logic [PHASE_W-1:0] phase,
  input  logic               awake,
  output logic               fire
);
  logic pend_q, pend_d, pend_ce;
  logic hit;

  always_comb begin
    hit     = exec_stb && awake && (instr == OPCODE) && (phase == PH_DECODE);
    pend_ce = hit || (phase == PH_COMMIT);
    pend_d  = hit;
    fire    = pend_q && (phase == PH_COMMIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_ce) pend_q <= pend_d;
  end
endmodule

// File: rtl/slp_wake.sv
module slp_wake
  import slp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PHASE_W-1:0] phase,
  input  logic               fire,
  input  logic               wdt_timeout,
  input  logic               wake_evt,
  output logic               asleep,
  output logic               wdt_wake
);
  logic sleep_q, sleep_d, sleep_ce;
  logic req_q, req_d, req_ce;
  logic any_wake;

  always_comb begin
    wdt_wake = sleep_q && wdt_timeout;
    any_wake = sleep_q && (req_q || wdt_timeout || wake_evt);
    // leave sleep only at the close of phase 4
    sleep_ce = fire || (any_wake && (phase == PH_COMMIT));
    sleep_d  = fire;
    req_ce   = any_wake;
    req_d    = (phase != PH_COMMIT);
    asleep   = sleep_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      if (sleep_ce) sleep_q <= sleep_d;
      if (req_ce)   req_q   <= req_d;
    end
  end
endmodule

// File: rtl/slp_status.sv
module slp_status (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic wdt_wake,
  output logic to_bit,
  output logic pd_bit
);
  logic to_q, to_d, to_ce;
  logic pd_q, pd_d, pd_ce;

  always_comb begin
    to_ce = fire || wdt_wake;
    to_d  = fire;
    pd_ce = fire;
    pd_d  = 1'b0;
    to_bit = to_q;
    pd_bit = pd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_q <= 1'b1;
      pd_q <= 1'b1;
    end else begin
      if (to_ce) to_q <= to_d;
      if (pd_ce) pd_q <= pd_d;
    end
  end
endmodule

// File: rtl/slp_pwr_ctrl.sv
module slp_pwr_ctrl
  import slp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INSTR_W-1:0] instr,
  input  logic               exec_stb,
  input  logic [PHASE_W-1:0] phase,
  input  logic               wdt_timeout,
  input  logic               wake_evt,
  output logic               wdt_clr,
  output logic               wdt_post_clr,
  output logic               stat_to,
  output logic               stat_pd,
  output logic               core_clk_en
);
  logic fire, asleep, wdt_wake;

  slp_decode u_dec (
    .clk(clk), .rst_n(rst_n), .instr(instr), .exec_stb(exec_stb),
    .phase(phase), .awake(!asleep), .fire(fire)
  );

  slp_wake u_wake (
    .clk(clk), .rst_n(rst_n), .phase(phase), .fire(fire),
    .wdt_timeout(wdt_timeout), .wake_evt(wake_evt),
    .asleep(asleep), .wdt_wake(wdt_wake)
  );

  slp_status u_stat (
    .clk(clk), .rst_n(rst_n), .fire(fire), .wdt_wake(wdt_wake),
    .to_bit(stat_to), .pd_bit(stat_pd)
  );

  assign wdt_clr      = fire;
  assign wdt_post_clr = fire;
  assign core_clk_en  = !asleep;
endmodule

// File: rtl/slp_pwr_ctrl_chk.sv
module slp_pwr_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] phase,
  input logic       wdt_timeout,
  input logic       wdt_clr,
  input logic       wdt_post_clr,
  input logic       stat_to,
  input logic       stat_pd,
  input logic       core_clk_en
);
  p_clr_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_clr == wdt_post_clr);
  p_clr_phase4_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_clr |-> phase == 2'b11);
  p_clr_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_clr |=> !wdt_clr);
  p_sleep_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_clr |=> (!core_clk_en && stat_to && !stat_pd));
  p_to_wdt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_clk_en && wdt_timeout) |=> !stat_to);
  p_wake_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_clk_en) |-> phase == 2'b00);
  p_no_clr_asleep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !core_clk_en |-> !wdt_clr);
  p_pd_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_pd |=> !stat_pd);
endmodule

bind slp_pwr_ctrl slp_pwr_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase), .wdt_timeout(wdt_timeout),
  .wdt_clr(wdt_clr), .wdt_post_clr(wdt_post_clr), .stat_to(stat_to),
  .stat_pd(stat_pd), .core_clk_en(core_clk_en)
);

// File: tb/tb_slp_pwr_ctrl.sv
`timescale 1ns/1ps
module tb_slp_pwr_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] instr;
  logic        exec_stb, wdt_timeout, wake_evt;
  logic [1:0]  phase;
  logic        wdt_clr, wdt_post_clr, stat_to, stat_pd, core_clk_en;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  slp_pwr_ctrl dut (
    .clk(clk), .rst_n(rst_n), .instr(instr), .exec_stb(exec_stb),
    .phase(phase), .wdt_timeout(wdt_timeout), .wake_evt(wake_evt),
    .wdt_clr(wdt_clr), .wdt_post_clr(wdt_post_clr), .stat_to(stat_to),
    .stat_pd(stat_pd), .core_clk_en(core_clk_en)
  );

  task automatic chk(string req, string what, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // outputs packed as {clr, post_clr, to, pd} and clock-enable separately
  function automatic logic [3:0] outs();
    return {wdt_clr, wdt_post_clr, stat_to, stat_pd};
  endfunction

  // advance one cycle: phase steps, inputs return to idle, sample 1 ns later
  task automatic step();
    @(posedge clk);
    #1;
    phase       = phase + 2'd1;
    exec_stb    = 1'b0;
    instr       = 16'h0000;
    wdt_timeout = 1'b0;
    wake_evt    = 1'b0;
    #1;
  endtask

  task automatic goto_phase(logic [1:0] p);
    do step(); while (phase != p);
  endtask

  task automatic t_reset();
    chk("R1", "outs after reset", outs(), 4'b0011);
    chk("R1", "clk_en after reset", {3'b0, core_clk_en}, 4'b0001);
  endtask

  // strobes sleep in phase 1 and walks to the first cycle asleep
  task automatic t_enter(logic exp_to);
    goto_phase(2'b00);
    instr = 16'h0003; exec_stb = 1'b1; #1;
    step(); chk("R2", "no clear in phase 2", {2'b0, wdt_clr, wdt_post_clr}, 4'b0000);
    step(); chk("R2", "no clear in phase 3", {2'b0, wdt_clr, wdt_post_clr}, 4'b0000);
    step(); chk("R2", "clears in phase 4", {2'b0, wdt_clr, wdt_post_clr}, 4'b0011);
    chk("R2", "still awake in phase 4", {3'b0, core_clk_en}, 4'b0001);
    chk("R2", "status unchanged in phase 4", {2'b0, stat_to, stat_pd}, {2'b0, exp_to, 1'b1 & stat_pd});
    step(); chk("R3", "asleep: clr,post,to,pd", outs(), 4'b0010);
    chk("R3", "clk_en low", {3'b0, core_clk_en}, 4'b0000);
  endtask

  task automatic t_other_ops();
    goto_phase(2'b00);
    instr = 16'h0004; exec_stb = 1'b1; #1;
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R4", "wrong opcode outs", outs(), {2'b00, stat_to, stat_pd});
      if (wdt_clr) chk("R4", "wrong opcode clear", 4'b0001, 4'b0000);
    end
    for (int p = 1; p < 4; p++) begin
      goto_phase(p[1:0]);
      instr = 16'h0003; exec_stb = 1'b1; #1;
      goto_phase(2'b00);
      goto_phase(2'b11);
      chk("R4", "sleep word off phase 1: clr", {3'b0, wdt_clr}, 4'b0000);
      step();
      chk("R4", "sleep word off phase 1: clk_en", {3'b0, core_clk_en}, 4'b0001);
    end
  endtask

  task automatic t_wake_awake();
    goto_phase(2'b01);
    wdt_timeout = 1'b1; wake_evt = 1'b1; #1;
    step();
    chk("R7", "to after wake inputs awake", {3'b0, stat_to}, 4'b0001);
    chk("R7", "clk_en after wake inputs awake", {3'b0, core_clk_en}, 4'b0001);
  endtask

  task automatic t_wdt_wake();
    t_enter(1'b1);
    // first asleep cycle is phase 1: stay asleep a full cycle with strobes
    instr = 16'h0003; exec_stb = 1'b1; #1;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R7", "no early wake", {3'b0, core_clk_en}, 4'b0000);
      chk("R8", "no clear while asleep", {3'b0, wdt_clr}, 4'b0000);
    end
    step();  // phase 1 again, still asleep
    chk("R7", "still asleep next phase 1", {3'b0, core_clk_en}, 4'b0000);
    wdt_timeout = 1'b1; #1;
    step();
    chk("R5", "to cleared by watchdog", {3'b0, stat_to}, 4'b0000);
    step(); chk("R5", "asleep phase 3", {3'b0, core_clk_en}, 4'b0000);
    step(); chk("R5", "asleep phase 4", {3'b0, core_clk_en}, 4'b0000);
    chk("R8", "no clear in asleep phase 4", {3'b0, wdt_clr}, 4'b0000);
    step(); chk("R5", "awake at phase 1", {3'b0, core_clk_en}, 4'b0001);
    chk("R9", "pd stays 0", {3'b0, stat_pd}, 4'b0000);
  endtask

  task automatic t_evt_wake();
    t_enter(1'b0);
    step();  // phase 2
    wake_evt = 1'b1; #1;
    step(); chk("R6", "to stays 1", {3'b0, stat_to}, 4'b0001);
    chk("R6", "asleep phase 3", {3'b0, core_clk_en}, 4'b0000);
    step(); chk("R6", "asleep phase 4", {3'b0, core_clk_en}, 4'b0000);
    step(); chk("R6", "awake at phase 1", {3'b0, core_clk_en}, 4'b0001);
    chk("R9", "pd stays 0 after event wake", {3'b0, stat_pd}, 4'b0000);
    for (int i = 0; i < 4; i++) step();
    chk("R6", "stays awake", {3'b0, core_clk_en}, 4'b0001);
  endtask

  initial begin
    rst_n = 1'b0; instr = '0; exec_stb = 1'b0; phase = 2'b11;
    wdt_timeout = 1'b0; wake_evt = 1'b0;
    repeat (3) @(posedge clk);
    #1; t_reset();
    @(negedge clk); rst_n = 1'b1;
    step(); t_reset();
    t_other_ops();
    t_wake_awake();
    t_wdt_wake();
    t_evt_wake();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule